// File: doc/BRIEF.md
# Keyed Super-IO Configuration Port

This block is the configuration register file of a legacy I/O companion device. A host reaches it through two adjacent byte addresses on a small I/O bus. The lower address is the index port and the one above it is the data port. The file stays sealed until the host writes the entry key 0x55 to the index port. After that, each index-port write picks a register, and data-port accesses read or write the picked register. Writing the exit key 0xAA to the index port seals the file again.

The stored values leave the block as plain outputs, ready to be wired to the rest of the device:
- power enables for two serial channels;
- an I/O base and an IRQ number for each channel;
- a relocatable base for a runtime register block, with its decode enable.

The address of the port pair is not fixed. It is picked from four choices by two strap inputs, which are sampled while reset is held and frozen when reset is released.

Control is a two-state machine:
- `ST_LOCKED` is the reset state. The entry-key transition (an index-port write of 0x55) moves it to `ST_OPEN`.
- `ST_OPEN` takes the exit-key transition (an index-port write of 0xAA) back to `ST_LOCKED`. Every other index-port write in `ST_OPEN` is stored as the selected index.

Top module: `ksio_cfg_port`

## Requirements
- R1: After reset every register reads zero, so `ser_pwr_en`, `ser0_base`, `ser1_base`, `ser0_irq`, `ser1_irq`, `rt_base` and `rt_decode_en` are all 0, the state is locked, and the selected index is 0x00.
- R2: While `rst_n` is low, `strap_sel` is sampled on each clock; once reset is released, the value is frozen and later strap changes have no effect. The index-port address maps as 00→0x002E, 01→0x004E, 10→0x162E, 11→0x164E, and the data port is that address plus one. Accesses to any other address are ignored and read 0x00.
- R3: An index-port write of 0x55 while locked opens the file. An index-port write of 0xAA while open locks it. Any other index-port value written while locked leaves the file locked.
- R4: While the file is open, an index-port write (other than 0xAA) selects that index. Reading the index port returns the selected index, and data-port accesses read or write the selected register. The entry key itself does not change the index.
- R5: While the file is locked, data-port writes change no register, and reads of either port return 0xFF.
- R6: Index 0x02 is power control. Bit 3 drives `ser_pwr_en[0]` and bit 7 drives `ser_pwr_en[1]`.
- R7: Indices 0x24 and 0x25 hold the I/O bases of serial channels 0 and 1 as address>>2. Only bits 7:1 are used, so the `serN_base` output equals {reg[7:1], 3'b000}. All 8 bits read back as written.
- R8: Index 0x28 routes IRQs. Bits 7:4 drive `ser0_irq` and bits 3:0 drive `ser1_irq`.
- R9: Index 0x30 holds the runtime base as address>>4, and index 0x21 bits 3:0 hold address>>12, so `rt_base` = {reg21[3:0], reg30, 4'h0}. Bit 1 of index 0x3A drives `rt_decode_en`.
- R10: An open data-port write to an unimplemented index is discarded and leaves every output unchanged. An open data-port read of an unimplemented index returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; straps are sampled while it is low |
| strap_sel | input | 2 | Selects the port-pair address |
| io_addr | input | 16 | I/O bus address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data (combinational) |
| ser_pwr_en | output | 2 | Serial channel power enables |
| ser0_base | output | 10 | Serial channel 0 I/O base |
| ser1_base | output | 10 | Serial channel 1 I/O base |
| ser0_irq | output | 4 | Serial channel 0 IRQ number |
| ser1_irq | output | 4 | Serial channel 1 IRQ number |
| rt_base | output | 16 | Runtime block I/O base |
| rt_decode_en | output | 1 | Runtime block decode enable |

## Verification
The hardest situation to reach is a change of strap value. The straps count only while reset is held, so the bench runs a second reset with new strap values and changes the straps again after reset is released. It then shows that the old address no longer responds and the new one does. The bench also hides effects behind the lock: it leaves the index on a live register, locks the file, and writes through the data port. The outputs must stay unchanged and reads must return 0xFF.

// File: rtl/ksio_pkg.sv
package ksio_pkg;

    localparam int IO_ADDR_W  = 16;
    localparam int BYTE_W     = 8;
    localparam int IRQ_W      = 4;
    localparam int SER_BASE_W = 10;
    localparam int STRAP_W    = 2;
    localparam int NUM_SER    = 2;

    localparam logic [BYTE_W-1:0] KEY_ENTER = 8'h55;
    localparam logic [BYTE_W-1:0] KEY_EXIT  = 8'hAA;
    localparam logic [BYTE_W-1:0] BUS_IDLE  = 8'hFF;

    localparam logic [BYTE_W-1:0] IDX_POWER    = 8'h02;
    localparam logic [BYTE_W-1:0] IDX_RT_HI    = 8'h21;
    localparam logic [BYTE_W-1:0] IDX_SER0_B   = 8'h24;
    localparam logic [BYTE_W-1:0] IDX_SER1_B   = 8'h25;
    localparam logic [BYTE_W-1:0] IDX_IRQ      = 8'h28;
    localparam logic [BYTE_W-1:0] IDX_RT_LO    = 8'h30;
    localparam logic [BYTE_W-1:0] IDX_ACTIVATE = 8'h3A;

    typedef enum logic [0:0] {
        ST_LOCKED = 1'b0,
        ST_OPEN   = 1'b1
    } cfg_state_t;

    function automatic logic [IO_ADDR_W-1:0] port_base(input logic [STRAP_W-1:0] s);
        logic [IO_ADDR_W-1:0] b;
        b = s[0] ? 16'h004E : 16'h002E;
        if (s[1]) b = b | 16'h1600;
        return b;
    endfunction

    function automatic logic is_implemented(input logic [BYTE_W-1:0] idx);
        return (idx == IDX_POWER) || (idx == IDX_RT_HI) || (idx == IDX_SER0_B) ||
               (idx == IDX_SER1_B) || (idx == IDX_IRQ) || (idx == IDX_RT_LO) ||
               (idx == IDX_ACTIVATE);
    endfunction

endpackage

// File: rtl/ksio_addr_dec.sv
module ksio_addr_dec
    import ksio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [STRAP_W-1:0]   strap_sel,
    input  logic [IO_ADDR_W-1:0] io_addr,
    input  logic                 io_wr,
    input  logic                 io_rd,
    output logic                 idx_wr,
    output logic                 idx_rd,
    output logic                 dat_wr,
    output logic                 dat_rd
);

    logic [STRAP_W-1:0]   strap_q;
    logic [IO_ADDR_W-1:0] base;
    logic                 hit_idx;
    logic                 hit_dat;

    // Straps follow the pins while reset is held and freeze at release.
    always_ff @(posedge clk) begin
        if (!rst_n) strap_q <= strap_sel;
    end

    always_comb begin
        base    = port_base(strap_q);
        hit_idx = (io_addr == base);
        hit_dat = (io_addr == (base + 16'd1));
        idx_wr  = hit_idx && io_wr;
        idx_rd  = hit_idx && io_rd;
        dat_wr  = hit_dat && io_wr;
        dat_rd  = hit_dat && io_rd;
    end

    assert_strap_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(strap_q));

endmodule

// File: rtl/ksio_fsm.sv
module ksio_fsm
    import ksio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic              cfg_open,
    output logic [BYTE_W-1:0] index_q
);

    cfg_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: if (idx_wr && wdata == KEY_ENTER) state_d = ST_OPEN;
            ST_OPEN:   if (idx_wr && wdata == KEY_EXIT)  state_d = ST_LOCKED;
            default:   state_d = ST_LOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    // Output process: open flag and selected index.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            index_q <= '0;
        end else if (state_q == ST_OPEN && idx_wr && wdata != KEY_EXIT) begin
            index_q <= wdata;
        end
    end

    assign cfg_open = (state_q == ST_OPEN);

    assert_enter_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && idx_wr && wdata == KEY_ENTER) |=> cfg_open);
    assert_exit_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && idx_wr && wdata == KEY_EXIT) |=> !cfg_open);
    assert_stay_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && !(idx_wr && wdata == KEY_ENTER)) |=> !cfg_open);
    assert_locked_index_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open |=> $stable(index_q));

endmodule

// File: rtl/ksio_regfile.sv
module ksio_regfile
    import ksio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_open,
    input  logic [BYTE_W-1:0]     index_q,
    input  logic                  dat_wr,
    input  logic [BYTE_W-1:0]     wdata,
    output logic [BYTE_W-1:0]     rd_value,
    output logic [NUM_SER-1:0]    ser_pwr_en,
    output logic [SER_BASE_W-1:0] ser_base [NUM_SER],
    output logic [IRQ_W-1:0]      ser_irq  [NUM_SER],
    output logic [IO_ADDR_W-1:0]  rt_base,
    output logic                  rt_decode_en
);

    localparam int BASE_SHIFT = SER_BASE_W - (BYTE_W - 1);

    logic [BYTE_W-1:0] pwr_q, rt_hi_q, irq_q, rt_lo_q, act_q;
    logic [BYTE_W-1:0] sbase_q [NUM_SER];
    logic              wr_ok;

    assign wr_ok = cfg_open && dat_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr_q      <= '0;
            rt_hi_q    <= '0;
            irq_q      <= '0;
            rt_lo_q    <= '0;
            act_q      <= '0;
            sbase_q[0] <= '0;
            sbase_q[1] <= '0;
        end else if (wr_ok) begin
            unique case (index_q)
                IDX_POWER:    pwr_q      <= wdata;
                IDX_RT_HI:    rt_hi_q    <= wdata;
                IDX_SER0_B:   sbase_q[0] <= wdata;
                IDX_SER1_B:   sbase_q[1] <= wdata;
                IDX_IRQ:      irq_q      <= wdata;
                IDX_RT_LO:    rt_lo_q    <= wdata;
                IDX_ACTIVATE: act_q      <= wdata;
                default:      ;
            endcase
        end
    end

    always_comb begin
        unique case (index_q)
            IDX_POWER:    rd_value = pwr_q;
            IDX_RT_HI:    rd_value = rt_hi_q;
            IDX_SER0_B:   rd_value = sbase_q[0];
            IDX_SER1_B:   rd_value = sbase_q[1];
            IDX_IRQ:      rd_value = irq_q;
            IDX_RT_LO:    rd_value = rt_lo_q;
            IDX_ACTIVATE: rd_value = act_q;
            default:      rd_value = '0;
        endcase
    end

    // Per-channel field extraction.
    for (genvar c = 0; c < NUM_SER; c++) begin : g_ser
        assign ser_base[c] = {sbase_q[c][BYTE_W-1:1], {BASE_SHIFT{1'b0}}};
        assign ser_irq[c]  = irq_q[(NUM_SER-1-c)*IRQ_W +: IRQ_W];
    end

    assign ser_pwr_en   = {pwr_q[7], pwr_q[3]};
    assign rt_base      = {rt_hi_q[3:0], rt_lo_q, 4'h0};
    assign rt_decode_en = act_q[1];

    assert_locked_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && dat_wr) |=> $stable({pwr_q, rt_hi_q, irq_q, rt_lo_q, act_q,
                                           sbase_q[0], sbase_q[1]}));
    assert_unimpl_discard_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && !is_implemented(index_q)) |=> $stable({ser_pwr_en, rt_base, rt_decode_en,
                                                        ser_base[0], ser_base[1],
                                                        ser_irq[0], ser_irq[1]}));
    assert_power_map_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && index_q == IDX_POWER) |=> ser_pwr_en == {$past(wdata[7]), $past(wdata[3])});
    assert_unimpl_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !is_implemented(index_q) |-> rd_value == 8'h00);

endmodule

// File: rtl/ksio_cfg_port.sv
module ksio_cfg_port
    import ksio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            strap_sel,
    input  logic [15:0]           io_addr,
    input  logic                  io_wr,
    input  logic                  io_rd,
    input  logic [7:0]            io_wdata,
    output logic [7:0]            io_rdata,
    output logic [1:0]            ser_pwr_en,
    output logic [9:0]            ser0_base,
    output logic [9:0]            ser1_base,
    output logic [3:0]            ser0_irq,
    output logic [3:0]            ser1_irq,
    output logic [15:0]           rt_base,
    output logic                  rt_decode_en
);

    logic                  idx_wr, idx_rd, dat_wr, dat_rd;
    logic                  cfg_open;
    logic [BYTE_W-1:0]     index_q, rd_value;
    logic [SER_BASE_W-1:0] sb [NUM_SER];
    logic [IRQ_W-1:0]      si [NUM_SER];

    ksio_addr_dec u_dec (
        .clk(clk), .rst_n(rst_n), .strap_sel(strap_sel), .io_addr(io_addr),
        .io_wr(io_wr), .io_rd(io_rd),
        .idx_wr(idx_wr), .idx_rd(idx_rd), .dat_wr(dat_wr), .dat_rd(dat_rd)
    );

    ksio_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .wdata(io_wdata),
        .cfg_open(cfg_open), .index_q(index_q)
    );

    ksio_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_open(cfg_open), .index_q(index_q),
        .dat_wr(dat_wr), .wdata(io_wdata), .rd_value(rd_value),
        .ser_pwr_en(ser_pwr_en), .ser_base(sb), .ser_irq(si),
        .rt_base(rt_base), .rt_decode_en(rt_decode_en)
    );

    assign ser0_base = sb[0];
    assign ser1_base = sb[1];
    assign ser0_irq  = si[0];
    assign ser1_irq  = si[1];

    always_comb begin
        if (dat_rd)      io_rdata = cfg_open ? rd_value : BUS_IDLE;
        else if (idx_rd) io_rdata = cfg_open ? index_q  : BUS_IDLE;
        else             io_rdata = '0;
    end

    assert_locked_reads_ff_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((dat_rd || idx_rd) && !cfg_open) |-> io_rdata == 8'hFF);

endmodule

// File: tb/tb_ksio_cfg_port.sv
`timescale 1ns/1ps
module tb_ksio_cfg_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  strap_sel = 2'b01;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [1:0]  ser_pwr_en;
    logic [9:0]  ser0_base, ser1_base;
    logic [3:0]  ser0_irq, ser1_irq;
    logic [15:0] rt_base;
    logic        rt_decode_en;

    int checks = 0;
    int errors = 0;
    logic [15:0] base = 16'h004E;

    always #2.5 clk = ~clk;

    ksio_cfg_port dut (
        .clk(clk), .rst_n(rst_n), .strap_sel(strap_sel), .io_addr(io_addr),
        .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .ser_pwr_en(ser_pwr_en), .ser0_base(ser0_base), .ser1_base(ser1_base),
        .ser0_irq(ser0_irq), .ser1_irq(ser1_irq), .rt_base(rt_base),
        .rt_decode_en(rt_decode_en)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] s);
        @(negedge clk);
        rst_n = 1'b0;
        strap_sel = s;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(posedge clk);
        #1 io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        io_rd = 1'b0;
    endtask

    task automatic put_reg(input logic [7:0] idx, input logic [7:0] d);
        io_write(base, idx);
        io_write(base + 16'd1, d);
    endtask

    task automatic t_reset_state();
        logic [7:0] v;
        do_reset(2'b01);
        base = 16'h004E;
        check("R1 pwr", ser_pwr_en, 0);
        check("R1 bases", {ser0_base, ser1_base}, 0);
        check("R1 irqs", {ser0_irq, ser1_irq}, 0);
        check("R1 runtime", {rt_base, rt_decode_en}, 0);
        io_read(base + 16'd1, v);
        check("R1 locked data read", v, 8'hFF);
    endtask

    task automatic t_unlock();
        logic [7:0] v;
        io_write(base, 8'h12);
        io_read(base + 16'd1, v);
        check("R3 other key stays locked", v, 8'hFF);
        io_write(16'h002E, 8'h55);
        io_read(base + 16'd1, v);
        check("R2 wrong address ignored", v, 8'hFF);
        io_read(16'h002E, v);
        check("R2 foreign read zero", v, 8'h00);
        io_write(base, 8'h55);
        io_read(base, v);
        check("R4 index after entry", v, 8'h00);
        io_read(base + 16'd1, v);
        check("R3 opened, index0 unimpl", v, 8'h00);
    endtask

    task automatic t_power();
        logic [7:0] v;
        put_reg(8'h02, 8'h88);
        check("R6 both on", ser_pwr_en, 2'b11);
        io_write(base + 16'd1, 8'h08);
        check("R6 ch0 only", ser_pwr_en, 2'b01);
        io_read(base, v);
        check("R4 index readback", v, 8'h02);
        io_read(base + 16'd1, v);
        check("R4 data readback", v, 8'h08);
    endtask

    task automatic t_serial();
        logic [7:0] v;
        put_reg(8'h24, 8'hFE);
        check("R7 ch0 base", ser0_base, 10'h3F8);
        put_reg(8'h25, 8'hBF);
        check("R7 ch1 base bit0 unused", ser1_base, 10'h2F8);
        io_read(base + 16'd1, v);
        check("R7 full readback", v, 8'hBF);
        put_reg(8'h28, 8'h43);
        check("R8 ch0 irq", ser0_irq, 4'h4);
        check("R8 ch1 irq", ser1_irq, 4'h3);
    endtask

    task automatic t_runtime();
        put_reg(8'h30, 8'hA4);
        put_reg(8'h21, 8'h01);
        check("R9 rt base", rt_base, 16'h1A40);
        put_reg(8'h3A, 8'h02);
        check("R9 decode on", rt_decode_en, 1'b1);
        io_write(base + 16'd1, 8'hFD);
        check("R9 decode off", rt_decode_en, 1'b0);
    endtask

    task automatic t_unimpl();
        logic [7:0] v;
        put_reg(8'h03, 8'h5A);
        io_read(base + 16'd1, v);
        check("R10 unimpl read", v, 8'h00);
        check("R10 outputs kept", {ser_pwr_en, ser0_irq, ser1_irq, rt_base}, {2'b01, 4'h4, 4'h3, 16'h1A40});
    endtask

    task automatic t_lock();
        logic [7:0] v;
        io_write(base, 8'h02);
        io_write(base, 8'hAA);
        io_write(base + 16'd1, 8'h80);
        check("R5 locked write ignored", ser_pwr_en, 2'b01);
        io_read(base + 16'd1, v);
        check("R5 locked data read", v, 8'hFF);
        io_read(base, v);
        check("R5 locked index read", v, 8'hFF);
        io_write(base, 8'h55);
        io_read(base, v);
        check("R4 entry keeps index", v, 8'h02);
        io_write(base, 8'hAA);
    endtask

    task automatic t_straps();
        logic [7:0] v;
        do_reset(2'b11);
        @(negedge clk) strap_sel = 2'b00;
        base = 16'h164E;
        check("R1 reset clears pwr", ser_pwr_en, 2'b00);
        io_write(16'h002E, 8'h55);
        io_read(16'h002F, v);
        check("R2 late strap ignored", v, 8'h00);
        io_write(base, 8'h55);
        put_reg(8'h28, 8'hC5);
        check("R2 strap 11 address", {ser0_irq, ser1_irq}, 8'hC5);
    endtask

    initial begin
        t_reset_state();
        t_unlock();
        t_power();
        t_serial();
        t_runtime();
        t_unimpl();
        t_lock();
        t_straps();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule